// File: doc/BRIEF.md
# Audio Clock Mode and Enable Controller

This block sits next to an audio clock synthesizer and decides how that synthesizer is set up. A static strap chooses where settings come from. In pin mode, a two-bit frequency group and a rate bit arrive on plain pins. In register mode, a three-wire serial word carries the same fields plus one enable bit per clock output. Both sources feed one shared decode. That decode reports the sampling frequency and the frequencies due on the 256·fS output, the 384·fS output and the auxiliary output. The synthesizer reads these numbers. The analog loops themselves are outside this block.

The six clock outputs are modelled as source clocks that are passed through a gate. Each enable is brought into its own source clock domain and applied through a latch that is open only while the source is low, so an output never produces a shortened pulse. When a setting change alters a clock, the outputs affected by it are held low for a short window of master clock cycles, and a settle flag shows when that window has ended. In register mode, clearing all six enables raises a power-down request. The serial path keeps working while power-down is raised, so a later word can bring the clocks back.

The block has no streaming data path. Every port is plain control or status, so no valid/ready handshake applies.

Top module: `audclk_mode_ctrl`

## Requirements
- R1: Group code 2'b00 selects 48000 Hz, 2'b01 selects 44100 Hz and 2'b10 selects 32000 Hz. In register mode the code is word bits [1:0]; in pin mode it comes from `par_grp`.
- R2: A rate bit of 0 keeps the standard frequency and a rate bit of 1 doubles it (64000, 88200 or 96000 Hz). The rate bit is word bit 2 in register mode and `par_dbl` in pin mode.
- R3: `f256_hz` always equals 256 × `fs_hz`, and `f384_hz` always equals 384 × `fs_hz`.
- R4: `aux_hz` is 33868800 while `aux_half` is low and 16934400 while it is high.
- R5: Group code 2'b11 is reserved. When it arrives, the previous group is kept, the rate bit is still applied, and `grp_rsv` stays high until a legal group code arrives.
- R6: A serial word is 16 bits long and sent most significant bit first. Each bit is sampled on a rising edge of `sctl_clk`, and the whole word is applied on a rising edge of `sctl_ld`. Bits [15:10] hold the key 6'b011100. Bits [9:4] hold the enables for output indices 5..0. Bit 3 must be 0. Bit 2 is the rate bit and bits [1:0] are the group code.
- R7: In register mode, a word whose key is wrong or whose bit 3 is set changes no setting.
- R8: After reset the block selects 48000 Hz at standard rate, with all six enables on, `grp_rsv` low, `pwr_down` low and `settled` high.
- R9: `gclk_out[i]` follows `src_clk[i]` while output i is enabled. It stays low while output i is disabled or reset is asserted. Its enable changes only while `src_clk[i]` is low. The output indices are: 0 fixed 33.8688 MHz clock, 1 the 256·fS clock, 2 the 384·fS clock, 3 the auxiliary clock, 4 master copy A, 5 master copy B.
- R10: `pwr_down` is high only in register mode with all six enables cleared. A later valid word still takes effect while `pwr_down` is high.
- R11: In pin mode all six outputs are enabled and `pwr_down` stays low.
- R12: A change of the sampling frequency holds outputs 1 and 2 low and drives `settled` low for exactly 2 master cycles. A change of `aux_half` does the same for output 3. An update that changes neither leaves `settled` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock for the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode | input | 1 | Static strap: 1 = register mode, 0 = pin mode |
| aux_half | input | 1 | Auxiliary frequency select, 1 = half frequency |
| par_grp | input | 2 | Frequency group code used in pin mode |
| par_dbl | input | 1 | Rate bit used in pin mode |
| sctl_clk | input | 1 | Serial bit clock |
| sctl_dat | input | 1 | Serial data |
| sctl_ld | input | 1 | Serial load strobe |
| src_clk | input | 6 | Source clocks from the synthesizer, one per output index |
| gclk_out | output | 6 | Gated clock outputs |
| fs_hz | output | 17 | Selected sampling frequency in Hz |
| f256_hz | output | 26 | Frequency due on the 256·fS output in Hz |
| f384_hz | output | 26 | Frequency due on the 384·fS output in Hz |
| aux_hz | output | 26 | Frequency due on the auxiliary output in Hz |
| grp_rsv | output | 1 | The last group code applied was reserved |
| pwr_down | output | 1 | Power-down request |
| settled | output | 1 | No transition window is open |

## Verification
A pin change, or a rising edge of the load strobe, passes two synchronizer flops. The new settings, frequencies and flags appear on the third master edge after it. A gated clock then needs two more edges of its own source clock before its enable takes effect. The bench therefore waits at least ten master cycles after each stimulus and samples on the falling edge of the master clock. The gated clocks are watched for 300 ns to tell a running output from a quiet one. The length of the transition window is measured with a counter that adds one for each master falling edge at which `settled` is low. The counter is cleared just before each stimulus, so the window is counted in whole cycles and not sampled at one guessed instant.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int NUM_OUT   = 6;
  localparam int WORD_W    = 16;
  localparam int KEY_W     = 6;
  localparam int CE_LSB    = 4;
  localparam int RSV_BIT   = 3;
  localparam int DBL_BIT   = 2;
  localparam logic [KEY_W-1:0] WORD_KEY = 6'b011100;

  localparam int FS_W = 17;
  localparam int HZ_W = 26;

  localparam logic [1:0] GRP_48K  = 2'b00;
  localparam logic [1:0] GRP_44K1 = 2'b01;
  localparam logic [1:0] GRP_32K  = 2'b10;
  localparam logic [1:0] GRP_RSV  = 2'b11;

  localparam int BASE_48K  = 48000;
  localparam int BASE_44K1 = 44100;
  localparam int BASE_32K  = 32000;
  localparam int AUX_FULL  = 33868800;
  localparam int AUX_HALF  = 16934400;

  localparam int IDX_FIX = 0;
  localparam int IDX_256 = 1;
  localparam int IDX_384 = 2;
  localparam int IDX_AUX = 3;
  localparam int IDX_MCA = 4;
  localparam int IDX_MCB = 5;
endpackage

// File: rtl/audclk_ser_rx.sv
module audclk_ser_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              sld,
  output logic [WORD_W-1:0] word,
  output logic              load_pulse
);
  logic [SYNC_STAGES-1:0] clk_sh, dat_sh, ld_sh;
  logic                   clk_last, ld_last;
  logic [WORD_W-1:0]      shreg;
  logic                   clk_s, dat_s, ld_s, bit_rise;

  assign clk_s    = clk_sh[SYNC_STAGES-1];
  assign dat_s    = dat_sh[SYNC_STAGES-1];
  assign ld_s     = ld_sh[SYNC_STAGES-1];
  assign bit_rise = clk_s & ~clk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh   <= '0;
      dat_sh   <= '0;
      ld_sh    <= '0;
      clk_last <= 1'b0;
      ld_last  <= 1'b0;
      shreg    <= '0;
    end else begin
      clk_sh   <= {clk_sh[SYNC_STAGES-2:0], sclk};
      dat_sh   <= {dat_sh[SYNC_STAGES-2:0], sdat};
      ld_sh    <= {ld_sh[SYNC_STAGES-2:0], sld};
      clk_last <= clk_s;
      ld_last  <= ld_s;
      if (bit_rise) shreg <= {shreg[WORD_W-2:0], dat_s};
    end
  end

  assign word       = shreg;
  assign load_pulse = ld_s & ~ld_last;
endmodule

// File: rtl/audclk_settings.sv
module audclk_settings
  import audclk_pkg::*;
#(
  parameter int NUM_OUT     = 6,
  parameter int WORD_W      = 16,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_mode,
  input  logic               aux_pin,
  input  logic [1:0]         par_grp,
  input  logic               par_dbl,
  input  logic [WORD_W-1:0]  word,
  input  logic               load_pulse,
  output logic [1:0]         cur_grp,
  output logic               cur_dbl,
  output logic               cur_aux,
  output logic [NUM_OUT-1:0] gate_en,
  output logic               grp_rsv,
  output logic               pwr_down,
  output logic               settled
);
  localparam int PIN_W = 5;
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [NUM_OUT-1:0] FS_MASK  = NUM_OUT'((1 << IDX_256) | (1 << IDX_384));
  localparam logic [NUM_OUT-1:0] AUX_MASK = NUM_OUT'(1 << IDX_AUX);

  logic [SYNC_STAGES-1:0][PIN_W-1:0] pin_sh;
  logic               mode_s, aux_s, pdbl_s;
  logic [1:0]         pgrp_s;
  logic               req_valid, req_dbl;
  logic [1:0]         req_grp, nxt_grp;
  logic [NUM_OUT-1:0] req_ce, cur_ce, hold_mask, new_mask;
  logic               fs_chg, aux_chg, key_ok;
  logic [CNT_W-1:0]   cnt;

  assign {mode_s, aux_s, pgrp_s, pdbl_s} = pin_sh[SYNC_STAGES-1];

  // A serial word is accepted only with the right key and a clear reserved bit
  assign key_ok = (word[WORD_W-1 -: KEY_W] == WORD_KEY) && !word[RSV_BIT];

  always_comb begin
    if (mode_s) begin
      req_valid = load_pulse && key_ok;
      req_grp   = word[1:0];
      req_dbl   = word[DBL_BIT];
      req_ce    = word[CE_LSB +: NUM_OUT];
    end else begin
      req_valid = 1'b1;
      req_grp   = pgrp_s;
      req_dbl   = pdbl_s;
      req_ce    = '1;
    end
  end

  assign nxt_grp  = (req_grp == GRP_RSV) ? cur_grp : req_grp;
  assign fs_chg   = req_valid && ((nxt_grp != cur_grp) || (req_dbl != cur_dbl));
  assign aux_chg  = (aux_s != cur_aux);
  assign new_mask = (fs_chg ? FS_MASK : '0) | (aux_chg ? AUX_MASK : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sh    <= '0;
      cur_grp   <= GRP_48K;
      cur_dbl   <= 1'b0;
      cur_aux   <= 1'b0;
      cur_ce    <= '1;
      grp_rsv   <= 1'b0;
      cnt       <= '0;
      hold_mask <= '0;
    end else begin
      pin_sh[0] <= {ser_mode, aux_pin, par_grp, par_dbl};
      for (int s = 1; s < SYNC_STAGES; s++) pin_sh[s] <= pin_sh[s-1];
      cur_aux <= aux_s;
      if (req_valid) begin
        cur_grp <= nxt_grp;
        cur_dbl <= req_dbl;
        cur_ce  <= req_ce;
        grp_rsv <= (req_grp == GRP_RSV);
      end
      if (fs_chg || aux_chg) begin
        cnt       <= CNT_W'(HOLD_CYC);
        hold_mask <= new_mask | ((cnt != '0) ? hold_mask : '0);
      end else if (cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  assign settled  = (cnt == '0);
  assign gate_en  = cur_ce & ~(settled ? '0 : hold_mask);
  assign pwr_down = mode_s && (cur_ce == '0);

  AST_RSV_HOLDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grp == GRP_RSV) |=> (cur_grp == $past(cur_grp))); // R5
  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && load_pulse && !key_ok) |=> ($stable(cur_grp) && $stable(cur_dbl) && $stable(cur_ce))); // R7
  AST_PIN_MODE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |=> (&cur_ce)); // R11
  AST_PD_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (gate_en == '0)); // R10
  AST_WINDOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settled) |=> !settled); // R12
endmodule

// File: rtl/audclk_rate_decode.sv
module audclk_rate_decode
  import audclk_pkg::*;
#(
  parameter int FS_W = 17,
  parameter int HZ_W = 26
) (
  input  logic [1:0]      grp,
  input  logic            dbl,
  input  logic            aux,
  output logic [FS_W-1:0] fs_hz,
  output logic [HZ_W-1:0] f256_hz,
  output logic [HZ_W-1:0] f384_hz,
  output logic [HZ_W-1:0] aux_hz
);
  logic [FS_W-1:0] base;
  logic [HZ_W-1:0] fs_wide;

  always_comb begin
    case (grp)
      GRP_44K1: base = FS_W'(BASE_44K1);
      GRP_32K:  base = FS_W'(BASE_32K);
      default:  base = FS_W'(BASE_48K);
    endcase
  end

  assign fs_hz   = dbl ? (base << 1) : base;
  assign fs_wide = HZ_W'(fs_hz);
  assign f256_hz = fs_wide << 8;
  assign f384_hz = (fs_wide << 8) + (fs_wide << 7);
  assign aux_hz  = aux ? HZ_W'(AUX_HALF) : HZ_W'(AUX_FULL);
endmodule

// File: rtl/audclk_clk_gate.sv
module audclk_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic src_clk,
  input  logic en,
  output logic gclk
);
  logic [SYNC_STAGES-1:0] en_sh;
  logic                   en_lat;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) en_sh <= '0;
    else        en_sh <= {en_sh[SYNC_STAGES-2:0], en};
  end

  // Transparent only while the source is low, so the gate never cuts a high phase
  always_latch begin
    if (!rst_n)        en_lat = 1'b0;
    else if (!src_clk) en_lat = en_sh[SYNC_STAGES-1];
  end

  assign gclk = src_clk & en_lat;
endmodule

// File: rtl/audclk_mode_ctrl.sv
module audclk_mode_ctrl
  import audclk_pkg::*;
#(
  parameter int NUM_CLK  = NUM_OUT,
  parameter int HOLD_CYC = 2,
  parameter int SYNC_N   = 2
) (
  input  logic               clk_mst,
  input  logic               rst_n,
  input  logic               ser_mode,
  input  logic               aux_half,
  input  logic [1:0]         par_grp,
  input  logic               par_dbl,
  input  logic               sctl_clk,
  input  logic               sctl_dat,
  input  logic               sctl_ld,
  input  logic [NUM_CLK-1:0] src_clk,
  output logic [NUM_CLK-1:0] gclk_out,
  output logic [FS_W-1:0]    fs_hz,
  output logic [HZ_W-1:0]    f256_hz,
  output logic [HZ_W-1:0]    f384_hz,
  output logic [HZ_W-1:0]    aux_hz,
  output logic               grp_rsv,
  output logic               pwr_down,
  output logic               settled
);
  logic [WORD_W-1:0]  word;
  logic               load_pulse;
  logic [1:0]         cur_grp;
  logic               cur_dbl, cur_aux;
  logic [NUM_CLK-1:0] gate_en;

  audclk_ser_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_N)) u_rx (
    .clk(clk_mst), .rst_n(rst_n), .sclk(sctl_clk), .sdat(sctl_dat), .sld(sctl_ld),
    .word(word), .load_pulse(load_pulse)
  );

  audclk_settings #(.NUM_OUT(NUM_CLK), .WORD_W(WORD_W), .HOLD_CYC(HOLD_CYC),
                    .SYNC_STAGES(SYNC_N)) u_set (
    .clk(clk_mst), .rst_n(rst_n), .ser_mode(ser_mode), .aux_pin(aux_half),
    .par_grp(par_grp), .par_dbl(par_dbl), .word(word), .load_pulse(load_pulse),
    .cur_grp(cur_grp), .cur_dbl(cur_dbl), .cur_aux(cur_aux), .gate_en(gate_en),
    .grp_rsv(grp_rsv), .pwr_down(pwr_down), .settled(settled)
  );

  audclk_rate_decode #(.FS_W(FS_W), .HZ_W(HZ_W)) u_dec (
    .grp(cur_grp), .dbl(cur_dbl), .aux(cur_aux),
    .fs_hz(fs_hz), .f256_hz(f256_hz), .f384_hz(f384_hz), .aux_hz(aux_hz)
  );

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_gate
    audclk_clk_gate #(.SYNC_STAGES(SYNC_N)) u_gate (
      .rst_n(rst_n), .src_clk(src_clk[i]), .en(gate_en[i]), .gclk(gclk_out[i])
    );
  end

  AST_FS_LEGAL: assert property (@(posedge clk_mst) disable iff (!rst_n)
    fs_hz inside {32000, 44100, 48000, 64000, 88200, 96000}); // R1
  AST_RSV_NEVER_DECODED: assert property (@(posedge clk_mst) disable iff (!rst_n)
    cur_grp != GRP_RSV); // R5
endmodule

// File: tb/audclk_mode_ctrl_bench.sv
module audclk_mode_ctrl_bench;
  logic       clk_mst = 1'b0, rst_n = 1'b0, ser_mode = 1'b0, aux_half = 1'b0;
  logic       par_dbl = 1'b0, sctl_clk = 1'b0, sctl_dat = 1'b0, sctl_ld = 1'b0;
  logic [1:0] par_grp = 2'b00;
  logic [5:0] src_clk = '0;
  logic [5:0] gclk_out;
  logic [16:0] fs_hz;
  logic [25:0] f256_hz, f384_hz, aux_hz;
  logic grp_rsv, pwr_down, settled;

  audclk_mode_ctrl u_audclk_mode_ctrl (
    .clk_mst(clk_mst), .rst_n(rst_n), .ser_mode(ser_mode), .aux_half(aux_half),
    .par_grp(par_grp), .par_dbl(par_dbl), .sctl_clk(sctl_clk), .sctl_dat(sctl_dat),
    .sctl_ld(sctl_ld), .src_clk(src_clk), .gclk_out(gclk_out), .fs_hz(fs_hz),
    .f256_hz(f256_hz), .f384_hz(f384_hz), .aux_hz(aux_hz), .grp_rsv(grp_rsv),
    .pwr_down(pwr_down), .settled(settled)
  );

  always #5 clk_mst = ~clk_mst;
  always #4 src_clk[0] = ~src_clk[0];
  always #6 src_clk[1] = ~src_clk[1];
  always #7 src_clk[2] = ~src_clk[2];
  always #5 src_clk[3] = ~src_clk[3];
  always #8 src_clk[4] = ~src_clk[4];
  always #9 src_clk[5] = ~src_clk[5];

  int n_chk = 0, n_bad = 0, win_cnt = 0;
  logic win_clr = 1'b0, done = 1'b0;
  localparam logic [5:0] KEY = 6'b011100;

  always @(negedge clk_mst) begin
    if (win_clr) win_cnt = 0;
    else if (!settled) win_cnt = win_cnt + 1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_mst);
  endtask

  task automatic start_window();
    win_clr = 1'b1;
    @(negedge clk_mst);
    #1 win_clr = 1'b0;
  endtask

  task automatic watch_gates(output logic [5:0] seen);
    seen = '0;
    repeat (300) begin #1; seen |= gclk_out; end
  endtask

  task automatic send(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) begin
      sctl_dat = w[b]; #40; sctl_clk = 1'b1; #40; sctl_clk = 1'b0;
    end
    #40 sctl_ld = 1'b1; #60 sctl_ld = 1'b0; #40;
    wait_clk(10);
  endtask

  function automatic logic [15:0] mk(input logic [5:0] key, input logic [5:0] ce,
                                     input logic dbl, input logic [1:0] grp);
    return {key, ce, 1'b0, dbl, grp};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    check("R9 gclk low in reset", gclk_out, 0);
    rst_n = 1'b1;
    wait_clk(6);
  endtask

  typedef struct packed {
    logic [1:0]  grp;
    logic        dbl;
    logic        aux;
    logic [16:0] fs;
    logic        rsv;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'b00, 1'b0, 1'b0, 17'd48000, 1'b0},
    '{2'b01, 1'b0, 1'b0, 17'd44100, 1'b0},
    '{2'b10, 1'b0, 1'b1, 17'd32000, 1'b0},
    '{2'b00, 1'b1, 1'b0, 17'd96000, 1'b0},
    '{2'b01, 1'b1, 1'b1, 17'd88200, 1'b0},
    '{2'b10, 1'b1, 1'b1, 17'd64000, 1'b0},
    '{2'b11, 1'b1, 1'b1, 17'd64000, 1'b1},
    '{2'b11, 1'b0, 1'b1, 17'd32000, 1'b1},
    '{2'b00, 1'b0, 1'b0, 17'd48000, 1'b0}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] seen;
    int prev_fs, exp_win;
    logic prev_aux;

    // Pin mode: reset state
    do_reset();
    check("R8 fs after reset", fs_hz, 48000);
    check("R8 pwr_down after reset", pwr_down, 0);
    check("R8 settled after reset", settled, 1);
    check("R8 grp_rsv after reset", grp_rsv, 0);
    watch_gates(seen);
    check("R8 R9 all outputs running", seen, 6'h3F);

    // Pin mode vector table
    prev_fs = 48000; prev_aux = 1'b0;
    for (int i = 0; i < 9; i++) begin
      start_window();
      par_grp = VEC[i].grp; par_dbl = VEC[i].dbl; aux_half = VEC[i].aux;
      wait_clk(10);
      exp_win = (int'(VEC[i].fs) != prev_fs || VEC[i].aux != prev_aux) ? 2 : 0;
      check("R1 R2 fs_hz", fs_hz, VEC[i].fs);
      check("R3 f256_hz", f256_hz, VEC[i].fs * 256);
      check("R3 f384_hz", f384_hz, VEC[i].fs * 384);
      check("R4 aux_hz", aux_hz, VEC[i].aux ? 16934400 : 33868800);
      check("R5 grp_rsv", grp_rsv, VEC[i].rsv);
      check("R11 pwr_down in pin mode", pwr_down, 0);
      check("R12 window cycles", win_cnt, exp_win);
      prev_fs = int'(VEC[i].fs); prev_aux = VEC[i].aux;
    end
    watch_gates(seen);
    check("R11 pin mode outputs all on", seen, 6'h3F);

    // Register mode
    par_grp = 2'b00; par_dbl = 1'b0; aux_half = 1'b0; ser_mode = 1'b1;
    do_reset();
    check("R8 serial reset fs", fs_hz, 48000);
    check("R8 serial reset pwr_down", pwr_down, 0);

    start_window();
    send(mk(KEY, 6'b000000, 1'b0, 2'b00));
    check("R10 all enables clear", pwr_down, 1);
    check("R12 no frequency change", win_cnt, 0);
    watch_gates(seen);
    check("R9 R10 outputs quiet", seen, 6'h00);

    send(mk(6'b011101, 6'h3F, 1'b1, 2'b01));
    check("R7 bad key keeps pwr_down", pwr_down, 1);
    check("R7 bad key keeps fs", fs_hz, 48000);
    send({KEY, 6'h3F, 1'b1, 1'b1, 2'b01});
    check("R6 R7 reserved bit set ignored", pwr_down, 1);
    check("R6 R7 reserved bit set keeps fs", fs_hz, 48000);

    start_window();
    send(mk(KEY, 6'h3F, 1'b1, 2'b01));
    check("R6 R10 resume clears pwr_down", pwr_down, 0);
    check("R1 R2 serial fs", fs_hz, 88200);
    check("R3 serial f384", f384_hz, 33868800);
    check("R12 serial window", win_cnt, 2);
    watch_gates(seen);
    check("R9 outputs back on", seen, 6'h3F);

    start_window();
    send(mk(KEY, 6'h3F, 1'b0, 2'b11));
    check("R5 reserved keeps group", fs_hz, 44100);
    check("R5 reserved flag", grp_rsv, 1);
    check("R12 rate change window", win_cnt, 2);

    start_window();
    send(mk(KEY, 6'b000010, 1'b0, 2'b01));
    check("R5 legal code clears flag", grp_rsv, 0);
    check("R12 same frequency no window", win_cnt, 0);
    watch_gates(seen);
    check("R6 R9 only 256 output on", seen, 6'b000010);

    send(mk(KEY, 6'b100000, 1'b1, 2'b10));
    check("R1 R2 serial 64k", fs_hz, 64000);
    watch_gates(seen);
    check("R6 R9 only master copy B on", seen, 6'b100000);

    start_window();
    aux_half = 1'b1;
    wait_clk(10);
    check("R4 aux half in register mode", aux_hz, 16934400);
    check("R12 aux change window", win_cnt, 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule